// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins, at most 32 wide, placed behind a small register port. The port has an address, write data, a write strobe and combinational read data. The bank keeps an output latch for the pins. Each pin has its own direction bit and its own output-enable bit. Software writes the latch either as a whole word or one 16-bit half at a time; a half write carries a protect mask in its upper 16 bits. Pin inputs pass through a two-stage synchronizer. Software reads their settled values from a read-only register that is separate from the output latch.

Every pin can raise an interrupt. Three per-pin configuration vectors select the trigger: a kind bit (edge or level), a polarity bit and a both-edges bit. Together they give five modes: rising edge, falling edge, both edges, high level and low level. Detected events set sticky status bits. Software clears them by a write-one mask. Enabling and disabling go through two separate write-one registers, and either register reads back the enabled set. One interrupt line is the OR of status AND enable over all pins.

The parameter `PIN_COUNT` sets how many low-order pins are populated. The upper pins read as zero, ignore writes and never report status.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the output latch, direction, output enable, interrupt enable and status all read 0 and `irq` is low. The kind (offset 9) and polarity (offset 10) registers read as all populated bits set, so every pin starts in rising-edge mode. The both-edges register (offset 11) reads 0.
- R2: A write to offset 0 updates pins 15:0 and a write to offset 1 updates pins 31:16. In both cases `wdata[15:0]` is the new data and `wdata[31:16]` is a protect mask. A pin whose mask bit is 1 keeps its latch value. There is no masked read.
- R3: A write to offset 2 loads the whole output latch. Reading offset 0, 1 or 2 returns the whole latch.
- R4: Offset 3 is read-only and returns the pin inputs two clocks after they settle. It never returns the output latch.
- R5: `pinOut` equals the output latch. `pinOe` bit i is 1 only when direction bit i (offset 4, 1 = output) and output-enable bit i (offset 5) are both 1.
- R6: Writing a mask to offset 6 enables the pins whose mask bits are 1. Writing a mask to offset 7 disables the pins whose mask bits are 1. A 0 bit leaves a pin's enable unchanged. Reading offset 6 or 7 returns the enabled set.
- R7: Status (offset 8) bits are sticky. Writing a mask to offset 8 clears only the bits that are 1 in the mask. If a new event arrives in the same cycle as a clear, the event wins.
- R8: Trigger encoding per pin:
  - kind = 1 selects edge mode. If both-edges = 1, both edges trigger. Otherwise polarity 1 selects the rising edge and polarity 0 the falling edge.
  - kind = 0 selects level mode. Polarity 1 means high and polarity 0 means low.
  - An edge on a synchronized input sets status on the next clock.
- R9: In level mode, status is set again on every clock while the level persists, so a clear has no visible effect until the level goes away.
- R10: `irq` is high exactly when some pin has both status and enable set.
- R11: Pins at and above `PIN_COUNT` read as 0 in every register, ignore writes and never set status.
- R12: Reading an address with no register (offsets 12 and up) returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register word offset |
| wdata | input | 32 | Write data |
| wen | input | 1 | Write strobe, one cycle per write |
| rdata | output | 32 | Read data for `addr`, combinational |
| pinIn | input | 32 | Raw pin inputs, asynchronous |
| pinOut | output | 32 | Output latch to the pads |
| pinOe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check four things on every cycle:
- a status bit only falls after a clear write;
- the enable set only moves after a register write;
- `irq` never rises with an empty enable set;
- unpopulated bits never appear on the read data.

Only the bench's scenarios can show the rest: the exact value a masked half-write leaves, the two-clock input latency, each of the five trigger modes firing on the right transition, and a level pin re-setting right after it is cleared. The bench compares all of these cycle by cycle with a behavioural model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_W = 32;
  localparam int HALF_W = BANK_W / 2;

  localparam int OFS_OUT_LO = 0;
  localparam int OFS_OUT_HI = 1;
  localparam int OFS_OUT    = 2;
  localparam int OFS_PIN    = 3;
  localparam int OFS_DIR    = 4;
  localparam int OFS_OEN    = 5;
  localparam int OFS_EN_SET = 6;
  localparam int OFS_EN_CLR = 7;
  localparam int OFS_STS    = 8;
  localparam int OFS_KIND   = 9;
  localparam int OFS_POL    = 10;
  localparam int OFS_BOTH   = 11;

  typedef struct packed {
    logic wrOutLo;
    logic wrOutHi;
    logic wrOut;
    logic wrDir;
    logic wrOen;
    logic wrEnSet;
    logic wrEnClr;
    logic wrStsClr;
    logic wrKind;
    logic wrPol;
    logic wrBoth;
  } ctlStrobes_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wen,
  output ctlStrobes_t       strobes
);
  logic [31:0] ofs;
  assign ofs = 32'(addr);

  always_comb begin
    strobes          = '0;
    strobes.wrOutLo  = wen && (ofs == OFS_OUT_LO);
    strobes.wrOutHi  = wen && (ofs == OFS_OUT_HI);
    strobes.wrOut    = wen && (ofs == OFS_OUT);
    strobes.wrDir    = wen && (ofs == OFS_DIR);
    strobes.wrOen    = wen && (ofs == OFS_OEN);
    strobes.wrEnSet  = wen && (ofs == OFS_EN_SET);
    strobes.wrEnClr  = wen && (ofs == OFS_EN_CLR);
    strobes.wrStsClr = wen && (ofs == OFS_STS);
    strobes.wrKind   = wen && (ofs == OFS_KIND);
    strobes.wrPol    = wen && (ofs == OFS_POL);
    strobes.wrBoth   = wen && (ofs == OFS_BOTH);
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [31:0]       wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       pinIn,
  output logic [31:0]       rdata,
  output logic [31:0]       pinOut,
  output logic [31:0]       pinOe,
  output logic [31:0]       enQ,
  output logic [31:0]       stsQ
);
  localparam logic [BANK_W-1:0] POP_MASK =
    (PIN_COUNT >= BANK_W) ? {BANK_W{1'b1}} : ((BANK_W'(1) << PIN_COUNT) - BANK_W'(1));

  logic [BANK_W-1:0] outQ, dirQ, oenQ, kindQ, polQ, bothQ;
  logic [BANK_W-1:0] syncA, syncB, prevB;
  logic [BANK_W-1:0] hit;
  logic [BANK_W-1:0] halfMerged;

  // per-pin trigger decode
  for (genvar i = 0; i < BANK_W; i++) begin : g_trig
    logic riseEv, fallEv, edgeHit, levelHit;
    assign riseEv   = syncB[i] & ~prevB[i];
    assign fallEv   = ~syncB[i] & prevB[i];
    assign edgeHit  = bothQ[i] ? (riseEv | fallEv) : (polQ[i] ? riseEv : fallEv);
    assign levelHit = polQ[i] ? syncB[i] : ~syncB[i];
    assign hit[i]   = POP_MASK[i] & (kindQ[i] ? edgeHit : levelHit);
  end

  // masked half write: protect bit 1 keeps the latch bit
  always_comb begin
    halfMerged = outQ;
    if (strobes.wrOutLo)
      halfMerged[HALF_W-1:0] = (outQ[HALF_W-1:0] & wdata[BANK_W-1:HALF_W]) |
                               (wdata[HALF_W-1:0] & ~wdata[BANK_W-1:HALF_W]);
    if (strobes.wrOutHi)
      halfMerged[BANK_W-1:HALF_W] = (outQ[BANK_W-1:HALF_W] & wdata[BANK_W-1:HALF_W]) |
                                    (wdata[HALF_W-1:0] & ~wdata[BANK_W-1:HALF_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outQ  <= '0;
      dirQ  <= '0;
      oenQ  <= '0;
      enQ   <= '0;
      stsQ  <= '0;
      kindQ <= POP_MASK;
      polQ  <= POP_MASK;
      bothQ <= '0;
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn & POP_MASK;
      syncB <= syncA;
      prevB <= syncB;
      if (strobes.wrOut)
        outQ <= wdata & POP_MASK;
      else if (strobes.wrOutLo || strobes.wrOutHi)
        outQ <= halfMerged & POP_MASK;
      if (strobes.wrDir)  dirQ  <= wdata & POP_MASK;
      if (strobes.wrOen)  oenQ  <= wdata & POP_MASK;
      if (strobes.wrKind) kindQ <= wdata & POP_MASK;
      if (strobes.wrPol)  polQ  <= wdata & POP_MASK;
      if (strobes.wrBoth) bothQ <= wdata & POP_MASK;
      if (strobes.wrEnSet)
        enQ <= enQ | (wdata & POP_MASK);
      else if (strobes.wrEnClr)
        enQ <= enQ & ~wdata;
      // new events win over a same-cycle clear
      stsQ <= (strobes.wrStsClr ? (stsQ & ~wdata) : stsQ) | hit;
    end
  end

  always_comb begin
    case (32'(addr))
      OFS_OUT_LO, OFS_OUT_HI, OFS_OUT: rdata = outQ;
      OFS_PIN:                         rdata = syncB;
      OFS_DIR:                         rdata = dirQ;
      OFS_OEN:                         rdata = oenQ;
      OFS_EN_SET, OFS_EN_CLR:          rdata = enQ;
      OFS_STS:                         rdata = stsQ;
      OFS_KIND:                        rdata = kindQ;
      OFS_POL:                         rdata = polQ;
      OFS_BOTH:                        rdata = bothQ;
      default:                         rdata = '0;
    endcase
  end

  assign pinOut = outQ;
  assign pinOe  = dirQ & oenQ;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wen,
  output logic [31:0]       rdata,
  input  logic [31:0]       pinIn,
  output logic [31:0]       pinOut,
  output logic [31:0]       pinOe,
  output logic              irq
);
  ctlStrobes_t strobes;
  logic [31:0] enQ;
  logic [31:0] stsQ;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .addr    (addr),
    .wen     (wen),
    .strobes (strobes)
  );

  gpio_bank_dp #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .wdata   (wdata),
    .addr    (addr),
    .pinIn   (pinIn),
    .rdata   (rdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .enQ     (enQ),
    .stsQ    (stsQ)
  );

  assign irq = |(stsQ & enQ);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int PIN_COUNT = 32,
  parameter int ADDR_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wen,
  input logic [31:0]       rdata,
  input logic [31:0]       pinOe,
  input logic              irq,
  input logic [31:0]       enQ,
  input logic [31:0]       stsQ
);
  localparam logic [31:0] POP_MASK =
    (PIN_COUNT >= 32) ? 32'hFFFF_FFFF : ((32'd1 << PIN_COUNT) - 32'd1);

  logic clrWrite;
  assign clrWrite = wen && (32'(addr) == 8);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (enQ == '0 && stsQ == '0 && pinOe == '0)); // R1

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clrWrite) |-> (($past(stsQ) & ~stsQ) == '0)); // R7

  AST_EN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wen) |-> $stable(enQ)); // R6

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enQ != '0)); // R10

  AST_UNPOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~POP_MASK) == '0); // R11
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (addr),
  .wen   (wen),
  .rdata (rdata),
  .pinOe (pinOe),
  .irq   (irq),
  .enQ   (enQ),
  .stsQ  (stsQ)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  localparam int NPINS = 22;
  localparam logic [31:0] POP = 32'h003F_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wen = 1'b0;
  logic [31:0] pinIn = '0;
  logic [31:0] rdata, pinOut, pinOe;
  logic        irq;

  int compared = 0;
  int mismatched = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.PIN_COUNT(NPINS), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wen(wen),
    .rdata(rdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] mOut, mDir, mOen, mEn, mSts, mKind, mPol, mBoth, mS1, mS2, mPrev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mOut = 0; mDir = 0; mOen = 0; mEn = 0; mSts = 0;
      mKind = POP; mPol = POP; mBoth = 0; mS1 = 0; mS2 = 0; mPrev = 0;
    end else begin
      logic [31:0] ev;
      logic [31:0] o;
      ev = 0;
      for (int i = 0; i < NPINS; i++) begin
        bit up, dn;
        up = mS2[i] && !mPrev[i];
        dn = !mS2[i] && mPrev[i];
        if (mKind[i]) ev[i] = mBoth[i] ? (up || dn) : (mPol[i] ? up : dn);
        else          ev[i] = mPol[i] ? mS2[i] : !mS2[i];
      end
      if (wen && addr == 8) mSts = mSts & ~wdata;
      mSts = mSts | ev;
      if (wen) begin
        o = mOut;
        case (addr)
          0: for (int i = 0; i < 16; i++) if (!wdata[16+i]) o[i] = wdata[i];
          1: for (int i = 0; i < 16; i++) if (!wdata[16+i]) o[16+i] = wdata[i];
          2: o = wdata;
          4: mDir = wdata & POP;
          5: mOen = wdata & POP;
          6: mEn = mEn | (wdata & POP);
          7: mEn = mEn & ~wdata;
          9: mKind = wdata & POP;
          10: mPol = wdata & POP;
          11: mBoth = wdata & POP;
          default: ;
        endcase
        mOut = o & POP;
      end
      mPrev = mS2;
      mS2 = mS1;
      mS1 = pinIn & POP;
    end
  end

  function automatic logic [31:0] modelRead(input logic [3:0] a);
    case (a)
      0, 1, 2: return mOut;
      3: return mS2;
      4: return mDir;
      5: return mOen;
      6, 7: return mEn;
      8: return mSts;
      9: return mKind;
      10: return mPol;
      11: return mBoth;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] a);
    case (a)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      9, 10, 11: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock against the model
  always @(negedge clk) if (rst_n) begin
    check(tagOf(addr), rdata, modelRead(addr));
    check("R10", {31'd0, irq}, {31'd0, |(mSts & mEn)});
    check("R5", pinOut, mOut);
    check("R5", pinOe, mDir & mOen);
  end

  task automatic busWrite(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = 4'(a); wdata = d; wen = 1'b1;
    @(posedge clk); #1;
    wen = 1'b0;
  endtask

  task automatic expectRead(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    addr = 4'(a);
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  task automatic setPins(input logic [31:0] v, input int waitCycles);
    @(posedge clk); #1;
    pinIn = v;
    repeat (waitCycles) @(posedge clk);
  endtask

  initial begin : watchdog
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expectRead(2, 32'h0, "R1");
    expectRead(4, 32'h0, "R1");
    expectRead(6, 32'h0, "R1");
    expectRead(8, 32'h0, "R1");
    expectRead(9, POP, "R1");
    expectRead(10, POP, "R1");
    expectRead(11, 32'h0, "R1");
    check("R1", {31'd0, irq}, 32'd0);
    // R3 / R11 full write
    busWrite(2, 32'hFFFF_FFFF);
    expectRead(2, 32'h003F_FFFF, "R3");
    // R2 masked halves
    busWrite(0, {16'h00F0, 16'h1234});
    expectRead(0, 32'h003F_12F4, "R2");
    busWrite(1, {16'h0000, 16'hABCD});
    expectRead(1, 32'h000D_12F4, "R2");
    busWrite(1, {16'hFFFF, 16'h0000});
    expectRead(2, 32'h000D_12F4, "R2");
    // R5 direction and enable
    busWrite(4, 32'h0000_00FF);
    busWrite(5, 32'h0000_0F0F);
    @(negedge clk); check("R5", pinOe, 32'h0000_000F);
    // R4 input path, R11 upper pins dropped
    setPins(32'h0200_0155, 3);
    expectRead(3, 32'h0000_0155, "R4");
    // R7 clear all, R6 enable
    busWrite(8, 32'hFFFF_FFFF);
    expectRead(8, 32'h0, "R7");
    busWrite(6, 32'hFFC0_0003);
    expectRead(6, 32'h0000_0003, "R6");
    // R8 rising on pin1
    setPins(32'h0000_0157, 4);
    expectRead(8, 32'h0000_0002, "R8");
    @(negedge clk); check("R10", {31'd0, irq}, 32'd1);
    busWrite(8, 32'h0000_0002);
    expectRead(8, 32'h0, "R7");
    @(negedge clk); check("R10", {31'd0, irq}, 32'd0);
    busWrite(7, 32'h0000_0001);
    expectRead(7, 32'h0000_0002, "R6");
    // R8 falling on pin1
    busWrite(10, POP & ~32'h2);
    setPins(32'h0000_0155, 4);
    expectRead(8, 32'h0000_0002, "R8");
    // R8 both edges on pin2
    busWrite(8, 32'hFFFF_FFFF);
    busWrite(11, 32'h0000_0004);
    setPins(32'h0000_0151, 4);
    expectRead(8, 32'h0000_0004, "R8");
    busWrite(8, 32'h0000_0004);
    setPins(32'h0000_0155, 4);
    expectRead(8, 32'h0000_0004, "R8");
    // R9 level high on pin3
    busWrite(8, 32'hFFFF_FFFF);
    busWrite(9, POP & ~32'h8);
    expectRead(8, 32'h0, "R9");
    setPins(32'h0000_015D, 4);
    expectRead(8, 32'h0000_0008, "R9");
    busWrite(8, 32'h0000_0008);
    expectRead(8, 32'h0000_0008, "R9");
    setPins(32'h0000_0155, 4);
    busWrite(8, 32'h0000_0008);
    expectRead(8, 32'h0, "R9");
    // R11 unpopulated pin toggles
    busWrite(9, POP);
    setPins(32'hC000_0155, 4);
    setPins(32'h0000_0155, 4);
    expectRead(8, 32'h0, "R11");
    // R12 unmapped
    expectRead(12, 32'h0, "R12");
    expectRead(15, 32'h0, "R12");
    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule